// File: doc/BRIEF.md
# Histogram BIST Capture Engine

This block sits behind the digital output of an on-chip converter under test and turns a stream of sparse, irregular samples into a histogram. Each output code has its own bin counter. A second table holds the expected histogram for the stimulus. After a programmed number of samples the engine compares the two tables bin by bin. It raises flags for bins that stray beyond a tolerance and for bins that stay empty where counts were expected.

All table access goes through one serial test data register on a boundary-scan style capture/shift/update interface. Expected counts are shifted in one bin at a time. Each bin's index, acquired count, signed difference and the verdict flags are shifted out through the same register. The usual flow is:

1. Load the expected table.
2. Issue a clear, then a start.
3. Let the converter sample a ramp.
4. Read the verdict pins or scan out the bins.

A ramp into an ideal converter gives roughly equal counts. Clipping empties the outer bins and inflates their inner neighbours. A stuck bit leaves a set of bins empty.

Top module: `hist_bist`

## Requirements
- R1: While capturing, each cycle with `smp_valid_i` high adds one to the bin selected by `smp_code_i`.
- R2: A bin at its all-ones maximum does not wrap when hit again. Instead `overflow_o` is set and stays set until a clear.
- R3: A start pulse opens capture with a zero sample count. The sample that brings the count to `target_i` (at least 1) ends capture. `done_o` rises 2^CODE_W cycles after the clock edge that accepts that sample, and it holds until the next start or clear.
- R4: Reset and `clear_i` zero every acquired bin, the bin pointer, the overflow flag, the verdict and `done_o`; the expected table survives a clear.
- R5: The difference for a bin is the expected count minus the acquired count, carried as a CODE-independent (CNT_W+1)-bit two's-complement value.
- R6: `fail_o` is set when any bin's difference has a magnitude strictly greater than `tol_i`; a magnitude equal to `tol_i` passes.
- R7: `empty_o` is set when any bin has zero acquired count while its expected count is nonzero.
- R8: A capture cycle loads the register, LSB first, with: the bin pointer in bits [CODE_W-1:0]; the acquired count in the next CNT_W bits; the difference in the next CNT_W+1 bits; and then one bit each for done, fail, empty and overflow.
- R9: Each shift cycle moves the register one place toward bit 0. `tdi_i` enters the top bit, and `tdo_o` always shows bit 0.
- R10: Each update cycle advances the bin pointer by one, wrapping at 2^CODE_W. When `ref_load_i` is high, the same update also writes the register's count field (bits [CODE_W+CNT_W-1:CODE_W]) into the expected bin at the old pointer.
- R11: `fault_bin_o` holds the lowest-indexed bin that breaks R6 or R7, or 0 when none does.
- R12: Samples arriving before start or after capture has ended leave every bin unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a capture run |
| clear_i | input | 1 | Zero acquired bins, pointer and verdict |
| target_i | input | TGT_W | Number of samples per run |
| tol_i | input | CNT_W | Allowed difference magnitude per bin |
| smp_valid_i | input | 1 | Sample strobe |
| smp_code_i | input | CODE_W | Converter output code |
| tap_capture_i | input | 1 | Load the test data register |
| tap_shift_i | input | 1 | Shift the test data register |
| tap_update_i | input | 1 | Advance the bin pointer, optionally write expected bin |
| ref_load_i | input | 1 | Update writes the expected table |
| tdi_i | input | 1 | Serial data in |
| tdo_o | output | 1 | Serial data out (bit 0) |
| done_o | output | 1 | Run and comparison finished |
| fail_o | output | 1 | Some bin outside tolerance |
| empty_o | output | 1 | Some expected bin left empty |
| overflow_o | output | 1 | Some bin saturated |
| fault_bin_o | output | CODE_W | First offending bin |

## Verification
Bin increments and pointer steps show one cycle after the edge that takes them. `tdo_o` is valid right after the capture edge and after each shift edge. `done_o` and the verdict follow the final accepted sample by 2^CODE_W edges, because the comparison walks one bin per cycle. The bench's reference model advances on the same edges from the same inputs. Outputs are compared at every falling edge, so a result that is early or late by even one cycle is caught. Verdict pins are compared only once the model says the run is done.

// File: rtl/hist_pkg.sv
package hist_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CAPT  = 2'd1,
    ST_JUDGE = 2'd2,
    ST_FIN   = 2'd3
  } hist_state_e;

  // expected minus acquired
  function automatic int bin_delta(input int exp_cnt, input int got_cnt);
    return exp_cnt - got_cnt;
  endfunction

  // magnitude strictly above the allowance
  function automatic logic beyond_tol(input int delta, input int tol);
    int mag;
    mag = (delta < 0) ? -delta : delta;
    return (mag > tol);
  endfunction

  // bin expected to fill but never hit
  function automatic logic starved_bin(input int exp_cnt, input int got_cnt);
    return (got_cnt == 0) && (exp_cnt != 0);
  endfunction

endpackage

// File: rtl/hist_ctrl.sv
module hist_ctrl
  import hist_pkg::*;
#(
  parameter int CODE_W = 4,
  parameter int TGT_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              clear_i,
  input  logic              smp_valid_i,
  input  logic [TGT_W-1:0]  target_i,
  output logic              accept_o,
  output logic              scan_en_o,
  output logic [CODE_W-1:0] scan_idx_o,
  output logic              done_o
);
  localparam int NBINS = 1 << CODE_W;

  hist_state_e       state_q;
  logic [TGT_W-1:0]  seen_q;
  logic [TGT_W-1:0]  seen_nx;
  logic [CODE_W-1:0] idx_q;
  logic              last_smp;
  logic              last_idx;

  assign seen_nx    = seen_q + 1'b1;
  assign accept_o   = (state_q == ST_CAPT) && smp_valid_i && !clear_i && !start_i;
  assign scan_en_o  = (state_q == ST_JUDGE) && !clear_i && !start_i;
  assign scan_idx_o = idx_q;
  assign done_o     = (state_q == ST_FIN);
  assign last_smp   = accept_o && (seen_nx == target_i);
  assign last_idx   = (idx_q == CODE_W'(NBINS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      seen_q  <= '0;
      idx_q   <= '0;
    end else if (clear_i) begin
      state_q <= ST_IDLE;
      seen_q  <= '0;
      idx_q   <= '0;
    end else if (start_i) begin
      state_q <= ST_CAPT;
      seen_q  <= '0;
      idx_q   <= '0;
    end else begin
      case (state_q)
        ST_CAPT: begin
          if (accept_o) seen_q <= seen_nx;
          if (last_smp) begin
            state_q <= ST_JUDGE;
            idx_q   <= '0;
          end
        end
        ST_JUDGE: begin
          idx_q <= idx_q + 1'b1;
          if (last_idx) state_q <= ST_FIN;
        end
        default: ;
      endcase
    end
  end

  // R3: the final sample hands over to the comparison walk
  assert_end_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
    last_smp |=> (state_q == ST_JUDGE) && (idx_q == '0));

  // R3: done holds until a start or clear
  assert_done_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !clear_i && !start_i) |=> done_o);

endmodule

// File: rtl/hist_bins.sv
module hist_bins #(
  parameter int CODE_W = 4,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear_i,
  input  logic              inc_i,
  input  logic [CODE_W-1:0] inc_code_i,
  input  logic              exp_we_i,
  input  logic [CODE_W-1:0] exp_idx_i,
  input  logic [CNT_W-1:0]  exp_val_i,
  input  logic [CODE_W-1:0] rd_a_idx_i,
  output logic [CNT_W-1:0]  got_a_o,
  output logic [CNT_W-1:0]  exp_a_o,
  input  logic [CODE_W-1:0] rd_b_idx_i,
  output logic [CNT_W-1:0]  got_b_o,
  output logic [CNT_W-1:0]  exp_b_o,
  output logic              ovf_o
);
  localparam int NBINS = 1 << CODE_W;
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] got_q [NBINS];
  logic [CNT_W-1:0] exp_q [NBINS];
  logic [CNT_W-1:0] hit_cnt;
  logic             sat_hit;
  logic             ovf_q;

  assign hit_cnt = got_q[inc_code_i];
  assign sat_hit = inc_i && (hit_cnt == CNT_MAX);
  assign got_a_o = got_q[rd_a_idx_i];
  assign exp_a_o = exp_q[rd_a_idx_i];
  assign got_b_o = got_q[rd_b_idx_i];
  assign exp_b_o = exp_q[rd_b_idx_i];
  assign ovf_o   = ovf_q;

  for (genvar b = 0; b < NBINS; b++) begin : g_bin
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        got_q[b] <= '0;
      else if (clear_i)
        got_q[b] <= '0;
      else if (inc_i && !sat_hit && (inc_code_i == CODE_W'(b)))
        got_q[b] <= got_q[b] + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        exp_q[b] <= '0;
      else if (exp_we_i && (exp_idx_i == CODE_W'(b)))
        exp_q[b] <= exp_val_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ovf_q <= 1'b0;
    else if (clear_i) ovf_q <= 1'b0;
    else if (sat_hit) ovf_q <= 1'b1;
  end

  // R1: an accepted sample raises its bin by exactly one
  assert_bin_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_i && !sat_hit && !clear_i) |=> got_q[$past(inc_code_i)] == $past(hit_cnt) + 1'b1);

  // R2: a full bin stays full and flags overflow
  assert_no_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sat_hit && !clear_i) |=> (got_q[$past(inc_code_i)] == CNT_MAX) && ovf_o);

  // R4: clear empties the bin seen on read port A
  assert_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> (got_a_o == '0) && !ovf_o);

endmodule

// File: rtl/hist_judge.sv
module hist_judge
  import hist_pkg::*;
#(
  parameter int CODE_W = 4,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart_i,
  input  logic              scan_en_i,
  input  logic [CODE_W-1:0] scan_idx_i,
  input  logic [CNT_W-1:0]  got_i,
  input  logic [CNT_W-1:0]  exp_i,
  input  logic [CNT_W-1:0]  tol_i,
  output logic              fail_o,
  output logic              empty_o,
  output logic [CODE_W-1:0] fbin_o
);
  int          delta;
  logic        over;
  logic        starved;
  logic        bad_bin;
  logic        found_q;
  logic        fail_q;
  logic        empty_q;
  logic [CODE_W-1:0] fbin_q;

  assign delta   = bin_delta(int'(exp_i), int'(got_i));
  assign over    = scan_en_i && beyond_tol(delta, int'(tol_i));
  assign starved = scan_en_i && starved_bin(int'(exp_i), int'(got_i));
  assign bad_bin = over || starved;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fail_q  <= 1'b0;
      empty_q <= 1'b0;
      found_q <= 1'b0;
      fbin_q  <= '0;
    end else if (restart_i) begin
      fail_q  <= 1'b0;
      empty_q <= 1'b0;
      found_q <= 1'b0;
      fbin_q  <= '0;
    end else begin
      if (over)    fail_q  <= 1'b1;
      if (starved) empty_q <= 1'b1;
      if (bad_bin && !found_q) begin
        found_q <= 1'b1;
        fbin_q  <= scan_idx_i;
      end
    end
  end

  assign fail_o  = fail_q;
  assign empty_o = empty_q;
  assign fbin_o  = fbin_q;

  // R7: an expected bin left empty is reported
  assert_starved_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (starved && !restart_i) |=> empty_o);

  // R11: the first offending bin is the one recorded
  assert_first_bin_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (bad_bin && !found_q && !restart_i) |=> (fbin_o == $past(scan_idx_i)));

  // R6: a tolerance breach is reported
  assert_tol_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (over && !restart_i) |=> fail_o);

endmodule

// File: rtl/hist_tdr.sv
module hist_tdr #(
  parameter int CODE_W = 4,
  parameter int CNT_W  = 8
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  clear_i,
  input  logic                                  cap_i,
  input  logic                                  shift_i,
  input  logic                                  upd_i,
  input  logic                                  ref_load_i,
  input  logic                                  tdi_i,
  input  logic [CODE_W+CNT_W+CNT_W+1+4-1:0]     cap_word_i,
  output logic                                  tdo_o,
  output logic [CODE_W-1:0]                     ptr_o,
  output logic                                  exp_we_o,
  output logic [CNT_W-1:0]                      exp_val_o
);
  localparam int W = CODE_W + CNT_W + CNT_W + 1 + 4;

  logic [W-1:0]      sr_q;
  logic [CODE_W-1:0] ptr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       sr_q <= '0;
    else if (cap_i)   sr_q <= cap_word_i;
    else if (shift_i) sr_q <= {tdi_i, sr_q[W-1:1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ptr_q <= '0;
    else if (clear_i) ptr_q <= '0;
    else if (upd_i)   ptr_q <= ptr_q + 1'b1;
  end

  assign tdo_o     = sr_q[0];
  assign ptr_o     = ptr_q;
  assign exp_we_o  = upd_i && ref_load_i && !clear_i;
  assign exp_val_o = sr_q[CODE_W +: CNT_W];

  // R8: capture loads the assembled word
  assert_capture_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cap_i |=> (sr_q == $past(cap_word_i)));

  // R9: shift moves toward bit 0 with tdi at the top
  assert_shift_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_i && !cap_i) |=> (sr_q[W-1] == $past(tdi_i)) && (sr_q[W-2:0] == $past(sr_q[W-1:1])));

  // R10: update steps the pointer by one
  assert_ptr_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_i && !clear_i) |=> (ptr_q == $past(ptr_q) + 1'b1));

endmodule

// File: rtl/hist_bist.sv
module hist_bist
  import hist_pkg::*;
#(
  parameter int CODE_W = 4,
  parameter int CNT_W  = 8,
  parameter int TGT_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              clear_i,
  input  logic [TGT_W-1:0]  target_i,
  input  logic [CNT_W-1:0]  tol_i,
  input  logic              smp_valid_i,
  input  logic [CODE_W-1:0] smp_code_i,
  input  logic              tap_capture_i,
  input  logic              tap_shift_i,
  input  logic              tap_update_i,
  input  logic              ref_load_i,
  input  logic              tdi_i,
  output logic              tdo_o,
  output logic              done_o,
  output logic              fail_o,
  output logic              empty_o,
  output logic              overflow_o,
  output logic [CODE_W-1:0] fault_bin_o
);
  localparam int DW    = CNT_W + 1;
  localparam int TDR_W = CODE_W + CNT_W + DW + 4;

  logic              accept;
  logic              scan_en;
  logic [CODE_W-1:0] scan_idx;
  logic [CODE_W-1:0] ptr;
  logic              exp_we;
  logic [CNT_W-1:0]  exp_val;
  logic [CNT_W-1:0]  got_s;
  logic [CNT_W-1:0]  exp_s;
  logic [CNT_W-1:0]  got_p;
  logic [CNT_W-1:0]  exp_p;
  logic [DW-1:0]     diff_p;
  logic [TDR_W-1:0]  cap_word;
  logic              restart;

  assign restart = start_i | clear_i;
  assign diff_p  = DW'(bin_delta(int'(exp_p), int'(got_p)));
  assign cap_word = {overflow_o, empty_o, fail_o, done_o, diff_p, got_p, ptr};

  hist_ctrl #(.CODE_W(CODE_W), .TGT_W(TGT_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .clear_i    (clear_i),
    .smp_valid_i(smp_valid_i),
    .target_i   (target_i),
    .accept_o   (accept),
    .scan_en_o  (scan_en),
    .scan_idx_o (scan_idx),
    .done_o     (done_o)
  );

  hist_bins #(.CODE_W(CODE_W), .CNT_W(CNT_W)) u_bins (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear_i    (clear_i),
    .inc_i      (accept),
    .inc_code_i (smp_code_i),
    .exp_we_i   (exp_we),
    .exp_idx_i  (ptr),
    .exp_val_i  (exp_val),
    .rd_a_idx_i (scan_idx),
    .got_a_o    (got_s),
    .exp_a_o    (exp_s),
    .rd_b_idx_i (ptr),
    .got_b_o    (got_p),
    .exp_b_o    (exp_p),
    .ovf_o      (overflow_o)
  );

  hist_judge #(.CODE_W(CODE_W), .CNT_W(CNT_W)) u_judge (
    .clk        (clk),
    .rst_n      (rst_n),
    .restart_i  (restart),
    .scan_en_i  (scan_en),
    .scan_idx_i (scan_idx),
    .got_i      (got_s),
    .exp_i      (exp_s),
    .tol_i      (tol_i),
    .fail_o     (fail_o),
    .empty_o    (empty_o),
    .fbin_o     (fault_bin_o)
  );

  hist_tdr #(.CODE_W(CODE_W), .CNT_W(CNT_W)) u_tdr (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear_i    (clear_i),
    .cap_i      (tap_capture_i),
    .shift_i    (tap_shift_i),
    .upd_i      (tap_update_i),
    .ref_load_i (ref_load_i),
    .tdi_i      (tdi_i),
    .cap_word_i (cap_word),
    .tdo_o      (tdo_o),
    .ptr_o      (ptr),
    .exp_we_o   (exp_we),
    .exp_val_o  (exp_val)
  );

  // R12: nothing is counted once the run has ended
  assert_ignore_late_R12: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !accept);

endmodule

// File: tb/hist_bist_bench.sv
module hist_bist_bench;
  localparam int CODE_W = 4;
  localparam int CNT_W  = 8;
  localparam int TGT_W  = 12;
  localparam int NB     = 16;
  localparam int W      = 25;
  localparam int MAXC   = 255;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 0, clear_i = 0, smp_valid_i = 0;
  logic [TGT_W-1:0] target_i = 0;
  logic [CNT_W-1:0] tol_i = 0;
  logic [CODE_W-1:0] smp_code_i = 0;
  logic cap = 0, shf = 0, upd = 0, rld = 0, tdi = 0;
  logic tdo_o, done_o, fail_o, empty_o, overflow_o;
  logic [CODE_W-1:0] fault_bin_o;

  always #4 clk = ~clk;

  hist_bist #(.CODE_W(CODE_W), .CNT_W(CNT_W), .TGT_W(TGT_W)) u_hist_bist (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .clear_i(clear_i),
    .target_i(target_i), .tol_i(tol_i), .smp_valid_i(smp_valid_i),
    .smp_code_i(smp_code_i), .tap_capture_i(cap), .tap_shift_i(shf),
    .tap_update_i(upd), .ref_load_i(rld), .tdi_i(tdi), .tdo_o(tdo_o),
    .done_o(done_o), .fail_o(fail_o), .empty_o(empty_o),
    .overflow_o(overflow_o), .fault_bin_o(fault_bin_o)
  );

  int checks = 0;
  int fails  = 0;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // ---------------- reference model ----------------
  int m_got [NB];
  int m_exp [NB];
  int m_ptr = 0, m_cnt = 0, m_wait = 0, m_fbin = 0;
  bit m_cap = 0, m_done = 0, m_ovf = 0, m_fail = 0, m_empty = 0;
  bit [W-1:0] m_sr = '0;

  function automatic bit [W-1:0] word_of();
    bit [W-1:0] w;
    int d;
    d = m_exp[m_ptr] - m_got[m_ptr];
    w = '0;
    w[3:0]   = 4'(m_ptr);
    w[11:4]  = 8'(m_got[m_ptr]);
    w[20:12] = 9'(d);
    w[21] = m_done; w[22] = m_fail; w[23] = m_empty; w[24] = m_ovf;
    return w;
  endfunction

  task automatic judge();
    bit found;
    found = 0; m_fail = 0; m_empty = 0; m_fbin = 0;
    for (int i = 0; i < NB; i++) begin
      int d;
      bit bt, bs;
      d  = m_exp[i] - m_got[i];
      bt = (d > int'(tol_i)) || (-d > int'(tol_i));
      bs = (m_got[i] == 0) && (m_exp[i] != 0);
      if (bt) m_fail = 1;
      if (bs) m_empty = 1;
      if ((bt || bs) && !found) begin found = 1; m_fbin = i; end
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NB; i++) begin m_got[i] = 0; m_exp[i] = 0; end
      m_ptr = 0; m_cnt = 0; m_wait = 0; m_cap = 0; m_done = 0;
      m_ovf = 0; m_fail = 0; m_empty = 0; m_fbin = 0; m_sr = '0;
    end else begin
      bit [W-1:0] cw, old;
      cw = word_of();
      old = m_sr;
      if (cap) m_sr = cw;
      else if (shf) m_sr = {tdi, old[W-1:1]};
      if (clear_i) m_ptr = 0;
      else if (upd) begin
        if (rld) m_exp[m_ptr] = int'(old[11:4]);
        m_ptr = (m_ptr + 1) % NB;
      end
      if (clear_i) begin
        for (int i = 0; i < NB; i++) m_got[i] = 0;
        m_cap = 0; m_done = 0; m_ovf = 0; m_wait = 0;
        m_fail = 0; m_empty = 0; m_fbin = 0; m_cnt = 0;
      end else if (start_i) begin
        m_cap = 1; m_cnt = 0; m_done = 0; m_wait = 0;
        m_fail = 0; m_empty = 0; m_fbin = 0;
      end else if (m_cap) begin
        if (smp_valid_i) begin
          if (m_got[smp_code_i] == MAXC) m_ovf = 1;
          else m_got[smp_code_i]++;
          m_cnt++;
          if (m_cnt == int'(target_i)) begin m_cap = 0; m_wait = NB; end
        end
      end else if (m_wait > 0) begin
        m_wait--;
        if (m_wait == 0) begin m_done = 1; judge(); end
      end
    end
  end

  // cycle-by-cycle comparison
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R3 done timing", int'(done_o), int'(m_done));
      chk("R2 overflow", int'(overflow_o), int'(m_ovf));
      chk("R9 tdo", int'(tdo_o), int'(m_sr[0]));
      if (m_done) begin
        chk("R6 fail", int'(fail_o), int'(m_fail));
        chk("R7 empty", int'(empty_o), int'(m_empty));
        chk("R11 fault bin", int'(fault_bin_o), m_fbin);
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic pulse_clear();
    clear_i = 1; @(negedge clk); clear_i = 0;
  endtask

  task automatic pulse_start(input int tgt);
    target_i = TGT_W'(tgt); start_i = 1; @(negedge clk); start_i = 0;
  endtask

  task automatic sample(input int code, input int gap);
    smp_valid_i = 1; smp_code_i = CODE_W'(code); @(negedge clk);
    smp_valid_i = 0;
    repeat (gap) @(negedge clk);
  endtask

  task automatic load_exp(input int val);
    bit [W-1:0] w;
    w = '0; w[11:4] = 8'(val);
    shf = 1;
    for (int i = 0; i < W; i++) begin tdi = w[i]; @(negedge clk); end
    shf = 0; tdi = 0;
    upd = 1; rld = 1; @(negedge clk); upd = 0; rld = 0;
  endtask

  task automatic wait_done();
    int n;
    n = 0;
    while (!m_done && n < 2000) begin @(negedge clk); n++; end
  endtask

  task automatic read_bin(input int idx, input int exp_cnt, input int exp_diff,
                          input string tag);
    bit [W-1:0] got;
    int d;
    while (m_ptr != idx) begin upd = 1; @(negedge clk); upd = 0; end
    cap = 1; @(negedge clk); cap = 0;
    shf = 1;
    for (int i = 0; i < W; i++) begin got[i] = tdo_o; @(negedge clk); end
    shf = 0;
    d = int'(got[20:12]);
    if (d >= 256) d -= 512;
    chk({"R8 index ", tag}, int'(got[3:0]), idx);
    chk({"R1 count ", tag}, int'(got[11:4]), exp_cnt);
    chk({"R5 diff ", tag}, d, exp_diff);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  // ---------------- test sequence ----------------
  initial begin
    repeat (2) @(negedge clk);
    chk("R4 reset done", int'(done_o), 0);
    chk("R4 reset overflow", int'(overflow_o), 0);
    chk("R4 reset fail", int'(fail_o), 0);
    rst_n = 1;
    @(negedge clk);

    // R10: expected table of 4 per bin through the shift register
    for (int b = 0; b < NB; b++) load_exp(4);
    tol_i = 2;

    // R12: samples before a start are dropped
    pulse_clear();
    sample(3, 1);
    sample(3, 0);
    read_bin(3, 0, 4, "R12 idle sample");

    // ideal ramp, sparse strobes
    pulse_clear();
    pulse_start(64);
    for (int k = 0; k < 64; k++) sample(k % NB, k % 3);
    wait_done();
    chk("R3 done after ramp", int'(done_o), 1);
    chk("R6 ramp pass", int'(fail_o), 0);
    read_bin(0, 4, 0, "ramp bin0");
    read_bin(9, 4, 0, "ramp bin9");
    // R12: late samples ignored
    sample(9, 0); sample(9, 2);
    read_bin(9, 4, 0, "R12 late sample");

    // clipped ramp: outer bins 1, neighbours 7
    pulse_clear();
    pulse_start(64);
    for (int b = 0; b < NB; b++) begin
      int n;
      n = (b == 0 || b == 15) ? 1 : (b == 1 || b == 14) ? 7 : 4;
      for (int k = 0; k < n; k++) sample(b, 1);
    end
    wait_done();
    chk("R6 clip fail", int'(fail_o), 1);
    chk("R11 clip first bin", int'(fault_bin_o), 0);
    read_bin(1, 7, -3, "clip bin1");

    // same pattern at tolerance 3: magnitude equal to tolerance passes
    tol_i = 3;
    pulse_start(64);
    pulse_clear();
    pulse_start(64);
    for (int b = 0; b < NB; b++) begin
      int n;
      n = (b == 0 || b == 15) ? 1 : (b == 1 || b == 14) ? 7 : 4;
      for (int k = 0; k < n; k++) sample(b, 0);
    end
    wait_done();
    chk("R6 boundary pass", int'(fail_o), 0);
    chk("R7 clip not empty", int'(empty_o), 0);

    // stuck low bit: odd bins never hit
    pulse_clear();
    pulse_start(64);
    for (int k = 0; k < 64; k++) sample((k * 2) % NB, 2);
    wait_done();
    chk("R7 stuck empty", int'(empty_o), 1);
    chk("R11 stuck first bin", int'(fault_bin_o), 0);
    read_bin(1, 0, 4, "R7 stuck bin1");

    // saturation
    pulse_clear();
    pulse_start(300);
    for (int k = 0; k < 300; k++) sample(5, 0);
    wait_done();
    chk("R2 overflow set", int'(overflow_o), 1);
    read_bin(5, MAXC, 4 - MAXC, "R2 saturated bin5");

    // R4: clear zeroes bins, keeps expected table
    pulse_clear();
    chk("R4 clear overflow", int'(overflow_o), 0);
    read_bin(5, 0, 4, "R4 after clear");

    repeat (4) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule